// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block controls one switchable power domain. Software writes a collapse request into a control word. The sequencer then takes the domain down or brings it back up through a fixed series of steps. Three plain logic outputs model the hardware: the power switch enable, the isolation clamp and the domain reset. Each switching step waits for a settle time that software sets in cycles. A status word, 4 bytes above the control word, reports progress. It has a live "fully powered" flag and two sticky completion flags, one for each direction.

The register port is a simple one-cycle write strobe with a combinational read. There is no stream data path, so there is no valid/ready handshake and no back-pressure. A write takes effect at the clock edge where `reg_wr` is high. `reg_rdata` always shows the word selected by `reg_addr`.

Top module: `pds_sequencer`

## Requirements
- R1: After reset the switch is closed (`sw_en`=1), isolation and domain reset are released, status bit 31 is 1 and bits 15 and 16 are 0. The control word reads collapse 0 and settle count `DEFAULT_SETTLE`.
- R2: The control word is at byte offset `CTRL_OFS` (default 0). Bit 0 is the collapse request. Bits [8 +: SETTLE_W] are the settle count. All other bits read 0. Any offset other than the control and status words reads 0. Reads are combinational in the same cycle as the address.
- R3: The status word is at `CTRL_OFS`+4. Bit 31 is 1 only while the domain is fully powered with no sequence running. Bit 16 is power-up complete and bit 15 is power-down complete. All other bits read 0, and writes to this offset change nothing.
- R4: A collapse request written at edge k while the domain is on asserts isolation from edge k+1, domain reset from edge k+2 and opens the switch from edge k+3. Status bit 31 clears from edge k+1.
- R5: Settle count S is the value held when the switch opens. Power-down completes at edge k+4+S, and at that edge bit 15 sets.
- R6: Clearing collapse at edge j while the domain is off closes the switch from edge j+1, using S as held at edge j+1. Domain reset releases at edge j+2+S. Isolation releases at edge j+3+S, and at that edge bits 16 and 31 set.
- R7: Setting either completion flag clears the other. The flags are never both 1, and each holds until the opposite sequence completes.
- R8: A change to the collapse request during a sequence does not alter it. The request is acted on one edge after the sequence completes.
- R9: A settle-count write during a wait does not change that wait's length.
- R10: Whenever the switch is open, isolation and domain reset are both asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| sw_en | output | 1 | Power switch enable, 1 = closed |
| iso_en | output | 1 | Isolation clamp, 1 = clamped |
| dom_rst | output | 1 | Domain reset, 1 = asserted |

## Verification
Every result is due a fixed number of edges after the write that causes it. The first step follows one edge after the write. The later steps follow the write at offsets of 2, 3, 3+S and 4+S edges for power-down, and at 2+S and 3+S edges for power-up. The bench holds a behavioural model that counts edges since the sequence began. The model samples the settle count at the edge where the hardware latches it. The model and the outputs are compared half a cycle after every edge, so each comparison sees settled values. Held requests and settle writes made during a wait are placed at known offsets, which gives an exact expected completion edge for each.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [2:0] {
    ST_ON     = 3'd0,
    ST_DN_ISO = 3'd1,
    ST_DN_RST = 3'd2,
    ST_DN_SW  = 3'd3,
    ST_OFF    = 3'd4,
    ST_UP_SW  = 3'd5,
    ST_UP_RST = 3'd6
  } pds_state_e;

  localparam int COLLAPSE_BIT = 0;
  localparam int SETTLE_LSB   = 8;
  localparam int DN_DONE_BIT  = 15;
  localparam int UP_DONE_BIT  = 16;
  localparam int PWR_ON_BIT   = 31;
endpackage

// File: rtl/pds_ctrl_regs.sv
module pds_ctrl_regs #(
  parameter int ADDR_W         = 8,
  parameter int SETTLE_W       = 8,
  parameter int DEFAULT_SETTLE = 4,
  parameter int CTRL_OFS       = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  input  logic                pwr_on,
  input  logic                up_done,
  input  logic                dn_done,
  output logic                collapse,
  output logic [SETTLE_W-1:0] settle,
  output logic [31:0]         reg_rdata
);
  import pds_pkg::*;

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(CTRL_OFS + 4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      collapse <= 1'b0;
      settle   <= SETTLE_W'(DEFAULT_SETTLE);
    end else if (reg_wr && reg_addr == CTRL_A) begin
      collapse <= reg_wdata[COLLAPSE_BIT];
      settle   <= reg_wdata[SETTLE_LSB +: SETTLE_W];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_A) begin
      reg_rdata[COLLAPSE_BIT]              = collapse;
      reg_rdata[SETTLE_LSB +: SETTLE_W]    = settle;
    end else if (reg_addr == STAT_A) begin
      reg_rdata[PWR_ON_BIT]  = pwr_on;
      reg_rdata[UP_DONE_BIT] = up_done;
      reg_rdata[DN_DONE_BIT] = dn_done;
    end
  end

  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == STAT_A) |=> (collapse == $past(collapse) && settle == $past(settle))); // R3
endmodule

// File: rtl/pds_seq_fsm.sv
module pds_seq_fsm #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                collapse,
  input  logic [SETTLE_W-1:0] settle,
  output logic                sw_en,
  output logic                iso_en,
  output logic                dom_rst,
  output logic                pwr_on,
  output logic                up_done,
  output logic                dn_done
);
  import pds_pkg::*;

  pds_state_e          state;
  logic [SETTLE_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_ON;
      cnt     <= '0;
      up_done <= 1'b0;
      dn_done <= 1'b0;
    end else begin
      case (state)
        ST_ON:     if (collapse) state <= ST_DN_ISO;
        ST_DN_ISO: state <= ST_DN_RST;
        ST_DN_RST: begin
          state <= ST_DN_SW;
          cnt   <= settle;
        end
        ST_DN_SW: begin
          if (cnt == '0) begin
            state   <= ST_OFF;
            dn_done <= 1'b1;
            up_done <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_OFF: begin
          if (!collapse) begin
            state <= ST_UP_SW;
            cnt   <= settle;
          end
        end
        ST_UP_SW: begin
          if (cnt == '0) state <= ST_UP_RST;
          else           cnt   <= cnt - 1'b1;
        end
        ST_UP_RST: begin
          state   <= ST_ON;
          up_done <= 1'b1;
          dn_done <= 1'b0;
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  always_comb begin
    sw_en   = 1'b1;
    iso_en  = 1'b1;
    dom_rst = 1'b1;
    case (state)
      ST_ON:     begin iso_en = 1'b0; dom_rst = 1'b0; end
      ST_DN_ISO: dom_rst = 1'b0;
      ST_DN_RST: ;
      ST_DN_SW:  sw_en = 1'b0;
      ST_OFF:    sw_en = 1'b0;
      ST_UP_SW:  ;
      ST_UP_RST: dom_rst = 1'b0;
      default:   sw_en = 1'b0;
    endcase
  end

  assign pwr_on = (state == ST_ON);

  AST_OPEN_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |-> (iso_en && dom_rst)); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_done && dn_done)); // R7
  AST_RST_AFTER_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dom_rst) |-> $past(iso_en)); // R4
  AST_ISO_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> (!dom_rst && $past(!dom_rst))); // R6
  AST_ON_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_on |-> (sw_en && !iso_en && !dom_rst)); // R3
endmodule

// File: rtl/pds_sequencer.sv
module pds_sequencer #(
  parameter int ADDR_W         = 8,
  parameter int SETTLE_W       = 8,
  parameter int DEFAULT_SETTLE = 4,
  parameter int CTRL_OFS       = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sw_en,
  output logic              iso_en,
  output logic              dom_rst
);
  logic                collapse;
  logic [SETTLE_W-1:0] settle;
  logic                pwr_on, up_done, dn_done;

  pds_ctrl_regs #(
    .ADDR_W(ADDR_W), .SETTLE_W(SETTLE_W),
    .DEFAULT_SETTLE(DEFAULT_SETTLE), .CTRL_OFS(CTRL_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pwr_on(pwr_on), .up_done(up_done),
    .dn_done(dn_done), .collapse(collapse), .settle(settle),
    .reg_rdata(reg_rdata)
  );

  pds_seq_fsm #(.SETTLE_W(SETTLE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .collapse(collapse), .settle(settle),
    .sw_en(sw_en), .iso_en(iso_en), .dom_rst(dom_rst),
    .pwr_on(pwr_on), .up_done(up_done), .dn_done(dn_done)
  );
endmodule

// File: tb/pds_sequencer_tb.sv
`timescale 1ns/100ps
module pds_sequencer_tb;
  localparam int DEF_S = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        sw_en, iso_en, dom_rst;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R1";
  logic [7:0] rd_addr = 8'd0;

  pds_sequencer #(.DEFAULT_SETTLE(DEF_S)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sw_en(sw_en), .iso_en(iso_en), .dom_rst(dom_rst)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference: edge count since the sequence began
  int m_coll = 0, m_settle = DEF_S, m_on = 1, m_busy = 0, m_dir = 0;
  int m_t = 0, m_s = 0, m_upd = 0, m_dnd = 0;

  always @(posedge clk) begin
    int pc, ps;
    cyc++;
    if (!rst_n) begin
      m_coll = 0; m_settle = DEF_S; m_on = 1; m_busy = 0;
      m_upd = 0; m_dnd = 0; m_t = 0;
    end else begin
      pc = m_coll; ps = m_settle;
      if (m_busy) begin
        m_t++;
        if (m_dir == 1 && m_t == 2) m_s = ps;
        if (m_dir == 1 && m_t == 3 + m_s) begin
          m_busy = 0; m_on = 0; m_dnd = 1; m_upd = 0;
        end else if (m_dir == 0 && m_t == 2 + m_s) begin
          m_busy = 0; m_on = 1; m_upd = 1; m_dnd = 0;
        end
      end else if (pc == 1 && m_on == 1) begin
        m_busy = 1; m_dir = 1; m_t = 0;
      end else if (pc == 0 && m_on == 0) begin
        m_busy = 1; m_dir = 0; m_t = 0; m_s = ps;
      end
      if (reg_wr && reg_addr == 8'd0) begin
        m_coll = int'(reg_wdata[0]);
        m_settle = int'(reg_wdata[15:8]);
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic e_sw, e_iso, e_rst;
    logic [31:0] e_rd;
    if (rst_n) begin
      if (m_busy && m_dir == 1) begin
        e_sw = (m_t < 2); e_iso = 1'b1; e_rst = (m_t >= 1);
      end else if (m_busy) begin
        e_sw = 1'b1; e_iso = 1'b1; e_rst = (m_t < 1 + m_s);
      end else begin
        e_sw = (m_on == 1); e_iso = (m_on == 0); e_rst = (m_on == 0);
      end
      e_rd = 32'd0;
      if (reg_addr == 8'd0) begin
        e_rd[0] = m_coll[0]; e_rd[15:8] = m_settle[7:0];
      end else if (reg_addr == 8'd4) begin
        e_rd[31] = (!m_busy && m_on == 1);
        e_rd[16] = m_upd[0]; e_rd[15] = m_dnd[0];
      end
      chk("sw_en /R10", {31'd0, sw_en}, {31'd0, e_sw});
      chk("iso_en /R10", {31'd0, iso_en}, {31'd0, e_iso});
      chk("dom_rst /R10", {31'd0, dom_rst}, {31'd0, e_rst});
      chk("reg_rdata", reg_rdata, e_rd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = rd_addr;
  endtask

  task automatic idle(input int n, input logic [7:0] a);
    rd_addr = a; reg_addr = a;
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tag = "R1";   idle(2, 8'd0); idle(2, 8'd4);
    tag = "R2";   wr(8'd0, 32'hFFFF_FF00); idle(2, 8'd0); idle(2, 8'd8);
    wr(8'd0, 32'h0000_0300);
    tag = "R3";   wr(8'd4, 32'hFFFF_FFFF); idle(2, 8'd4); idle(1, 8'd0);
    tag = "R4 R5"; rd_addr = 8'd4; wr(8'd0, 32'h0000_0301); idle(12, 8'd4);
    tag = "R6 R7"; wr(8'd0, 32'h0000_0300); idle(12, 8'd4);
    tag = "R5 R6"; wr(8'd0, 32'h0000_0001); idle(6, 8'd4);
    wr(8'd0, 32'h0000_0000); idle(6, 8'd4);
    tag = "R8";   wr(8'd0, 32'h0000_0501); idle(1, 8'd4);
    wr(8'd0, 32'h0000_0500); idle(14, 8'd4);
    wr(8'd0, 32'h0000_0501); idle(25, 8'd4);
    wr(8'd0, 32'h0000_0500); idle(25, 8'd4);
    tag = "R9";   wr(8'd0, 32'h0000_0401); idle(3, 8'd4);
    wr(8'd0, 32'h0000_0A01); idle(22, 8'd4);
    wr(8'd0, 32'h0000_0A00); idle(2, 8'd4);
    wr(8'd0, 32'h0000_0200); idle(22, 8'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule